// File: doc/BRIEF.md
# Time-Gain Compensation Staircase Sequencer

This block produces the gain code for a DAC that sets a variable-gain amplifier during an ultrasound-style acquisition line. Software first loads a table of 32 ten-bit gain levels through a write port. A line-start pulse, accepted only while the acquisition-active input is high, starts the line. The block then walks through the table one entry per segment, so the amplifier gain rises or falls as a staircase across the line. By default a segment is 1024 clock cycles, which is 8 µs at 128 MHz, and the 32 segments cover 256 µs.

The block leaves a line in three ways: the last segment runs out, a new line start restarts the staircase at entry 0, or acquisition-active drops. Outside a line the DAC code follows a separate idle level. A second output mirrors the DAC code so the present level can be read back. A table write that arrives while a line is running is held back. It is committed once the line is over, so the staircase of a running line never changes partway through.

Top module: `tgc_sequencer`

## Requirements
- R1: While `rst` is high, `dac_code` and `level_rb` are 0.
- R2: When no line is running, a write with `wr_en` high stores `wr_data` into entry `wr_addr`, where address 0 is the first segment. Any value from 0 to 1023 is kept exactly.
- R3: A line begins at the clock edge where `line_start` and `acq_active` are both high. Two edges after that edge, `dac_code` shows entry 0. Entry k is then shown for SEG_CYCLES consecutive cycles, followed by entry k+1.
- R4: A qualified `line_start` during a running line restarts the staircase at entry 0, with the same two-edge latency as R3.
- R5: After the last entry has been shown for its full SEG_CYCLES cycles, `dac_code` returns to the idle level and holds it until the next line start.
- R6: When no line is running, `dac_code` takes the value of `idle_level` one edge after `idle_level` is presented. `level_rb` always equals `dac_code`.
- R7: A table write made while a line is running does not change that line. It is committed to the table after the line ends.
- R8: Only one write is held during a line. A later write in the same line replaces the held write, and only the last one is committed.
- R9: If `acq_active` is sampled low during a line, the line ends and `dac_code` shows the idle level from the second edge after that sample onward. A held write is then committed.
- R10: A `line_start` pulse while `acq_active` is low is ignored, and the output keeps the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse that starts or restarts a line |
| acq_active | input | 1 | High while acquisition is enabled |
| idle_level | input | 10 | Gain code used outside a line |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 5 | Table entry index (segment number) |
| wr_data | input | 10 | Gain code to store |
| dac_code | output | 10 | Registered gain code sent to the DAC |
| level_rb | output | 10 | Readback copy of the present DAC level |

## Verification
The table read is synchronous and the output is registered, so a staircase entry reaches `dac_code` two edges after the line-start edge or segment boundary that selects it. The bench therefore counts edges from the accepted line start and compares every cycle of the line against a table snapshot taken at that moment. The idle level has a latency of one edge, and the bench samples it on the next falling edge. After a restart or an abort, the two cycles still draining the pipeline are not checked, and checking resumes at the cycle the requirement names. Held writes are checked through their effect on the following line.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  localparam int TGC_NUM_SEG    = 32;
  localparam int TGC_GAIN_W     = 10;
  localparam int TGC_SEG_CYCLES = 1024;
endpackage

// File: rtl/tgc_seg_timer.sv
module tgc_seg_timer #(
  parameter int NUM_SEG    = tgc_pkg::TGC_NUM_SEG,
  parameter int SEG_CYCLES = tgc_pkg::TGC_SEG_CYCLES,
  localparam int SW = $clog2(NUM_SEG),
  localparam int CW = $clog2(SEG_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_start,
  input  logic          acq_active,
  output logic          running,
  output logic [SW-1:0] seg_idx
);
  localparam logic [CW-1:0] LAST_CNT = CW'(SEG_CYCLES - 1);
  localparam logic [SW-1:0] LAST_SEG = SW'(NUM_SEG - 1);

  logic [CW-1:0] cyc_cnt;
  logic          go;

  assign go = line_start && acq_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      seg_idx <= '0;
      cyc_cnt <= '0;
    end else if (go) begin
      running <= 1'b1;
      seg_idx <= '0;
      cyc_cnt <= '0;
    end else if (running) begin
      if (!acq_active) begin
        running <= 1'b0;
        cyc_cnt <= '0;
      end else if (cyc_cnt == LAST_CNT) begin
        cyc_cnt <= '0;
        if (seg_idx == LAST_SEG) begin
          running <= 1'b0;
          seg_idx <= '0;
        end else begin
          seg_idx <= seg_idx + 1'b1;
        end
      end else begin
        cyc_cnt <= cyc_cnt + 1'b1;
      end
    end
  end

  a_r3_seg_hold: assert property (@(posedge clk) disable iff (rst)
    (running && acq_active && !line_start && cyc_cnt != LAST_CNT) |=> $stable(seg_idx));

  a_r3_seg_step: assert property (@(posedge clk) disable iff (rst)
    (running && acq_active && !line_start && cyc_cnt == LAST_CNT && seg_idx != LAST_SEG)
      |=> (seg_idx == $past(seg_idx) + 1'b1) && running);

  a_r4_restart: assert property (@(posedge clk) disable iff (rst)
    go |=> (running && seg_idx == '0 && cyc_cnt == '0));

  a_r5_end: assert property (@(posedge clk) disable iff (rst)
    (running && acq_active && !line_start && cyc_cnt == LAST_CNT && seg_idx == LAST_SEG)
      |=> !running);

  a_r9_abort: assert property (@(posedge clk) disable iff (rst)
    (running && !acq_active) |=> !running);

  a_r10_no_start: assert property (@(posedge clk) disable iff (rst)
    (!running && !(line_start && acq_active)) |=> !running);
endmodule

// File: rtl/tgc_write_hold.sv
module tgc_write_hold #(
  parameter int AW = 5,
  parameter int DW = tgc_pkg::TGC_GAIN_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_busy,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          ram_we,
  output logic [AW-1:0] ram_waddr,
  output logic [DW-1:0] ram_wdata
);
  logic          pend_valid;
  logic [AW-1:0] pend_addr;
  logic [DW-1:0] pend_data;

  always_comb begin
    ram_we    = !line_busy && (pend_valid || wr_en);
    ram_waddr = pend_valid ? pend_addr : wr_addr;
    ram_wdata = pend_valid ? pend_data : wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
    end else if (line_busy) begin
      if (wr_en) begin
        pend_valid <= 1'b1;
        pend_addr  <= wr_addr;
        pend_data  <= wr_data;
      end
    end else if (pend_valid) begin
      if (wr_en) begin
        pend_addr <= wr_addr;
        pend_data <= wr_data;
      end else begin
        pend_valid <= 1'b0;
      end
    end
  end

  a_r7_no_commit_busy: assert property (@(posedge clk) disable iff (rst)
    line_busy |-> !ram_we);

  a_r7_hold_on_busy: assert property (@(posedge clk) disable iff (rst)
    (line_busy && wr_en) |=> pend_valid);

  a_r8_flush: assert property (@(posedge clk) disable iff (rst)
    (pend_valid && !line_busy && !wr_en) |=> !pend_valid);
endmodule

// File: rtl/tgc_gain_ram.sv
module tgc_gain_ram #(
  parameter int DEPTH = tgc_pkg::TGC_NUM_SEG,
  parameter int DW    = tgc_pkg::TGC_GAIN_W,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tgc_sequencer.sv
module tgc_sequencer #(
  parameter int NUM_SEG    = tgc_pkg::TGC_NUM_SEG,
  parameter int GAIN_W     = tgc_pkg::TGC_GAIN_W,
  parameter int SEG_CYCLES = tgc_pkg::TGC_SEG_CYCLES,
  localparam int AW = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              acq_active,
  input  logic [GAIN_W-1:0] idle_level,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  output logic [GAIN_W-1:0] dac_code,
  output logic [GAIN_W-1:0] level_rb
);
  logic              running;
  logic              run_d;
  logic [AW-1:0]     seg_idx;
  logic              ram_we;
  logic [AW-1:0]     ram_waddr;
  logic [GAIN_W-1:0] ram_wdata;
  logic [GAIN_W-1:0] ram_rdata;

  tgc_seg_timer #(.NUM_SEG(NUM_SEG), .SEG_CYCLES(SEG_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .line_start(line_start), .acq_active(acq_active),
    .running(running), .seg_idx(seg_idx)
  );

  tgc_write_hold #(.AW(AW), .DW(GAIN_W)) u_hold (
    .clk(clk), .rst(rst), .line_busy(running),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  tgc_gain_ram #(.DEPTH(NUM_SEG), .DW(GAIN_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(seg_idx), .rdata(ram_rdata)
  );

  // run_d aligns the line flag with the one-cycle RAM read
  always_ff @(posedge clk) begin
    if (rst) begin
      run_d    <= 1'b0;
      dac_code <= '0;
      level_rb <= '0;
    end else begin
      run_d    <= running;
      dac_code <= run_d ? ram_rdata : idle_level;
      level_rb <= run_d ? ram_rdata : idle_level;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (dac_code == '0));

  a_r6_idle_follow: assert property (@(posedge clk) disable iff (rst)
    (!running && !run_d && !$past(running)) |=> (dac_code == $past(idle_level)));
endmodule

// File: tb/tgc_sequencer_test.sv
module tgc_sequencer_test;
  localparam int NS   = 32;
  localparam int GW   = 10;
  localparam int SC   = 8;
  localparam int AW   = 5;
  localparam int LINE = NS * SC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_start = 1'b0;
  logic          acq_active = 1'b0;
  logic [GW-1:0] idle_level = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [GW-1:0] wr_data = '0;
  logic [GW-1:0] dac_code;
  logic [GW-1:0] level_rb;

  int n_run = 0;
  int n_fail = 0;
  logic [GW-1:0] model [NS];

  always #10 clk = ~clk;

  tgc_sequencer #(.NUM_SEG(NS), .GAIN_W(GW), .SEG_CYCLES(SC)) uut (
    .clk(clk), .rst(rst), .line_start(line_start), .acq_active(acq_active),
    .idle_level(idle_level), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_code(dac_code), .level_rb(level_rb)
  );

  task automatic check(input string req, input logic [GW-1:0] exp);
    n_run++;
    if (dac_code !== exp || level_rb !== exp) begin
      n_fail++;
      $display("FAIL %s: dac_code=%0d level_rb=%0d expected %0d at %0t",
               req, dac_code, level_rb, exp, $time);
    end
  endtask

  task automatic write_entry(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = GW'(d);
    @(negedge clk);
    wr_en = 1'b0;
    model[a] = GW'(d);
  endtask

  // Full line with optional held writes and an optional abort cycle.
  task automatic run_line(input int abort_at, input int nwr,
                          input int wk[3], input int wa[3], input int wd[3]);
    logic [GW-1:0] tab [NS];
    logic [GW-1:0] idl;
    int last;
    for (int i = 0; i < NS; i++) tab[i] = model[i];
    idl = idle_level;
    last = -1;
    @(negedge clk);
    line_start = 1'b1; acq_active = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < LINE + 5; k++) begin
      wr_en = 1'b0;
      for (int i = 0; i < nwr; i++)
        if (wk[i] == k) begin
          wr_en = 1'b1; wr_addr = AW'(wa[i]); wr_data = GW'(wd[i]); last = i;
        end
      if (abort_at >= 0 && k == abort_at) acq_active = 1'b0;
      if (abort_at >= 0 && k > abort_at + 2)
        check("R9 idle after abort", idl);
      else if (abort_at >= 0 && k > abort_at)
        ;
      else if (k < 2)
        check("R3 pre-line latency", idl);
      else if (k - 2 < LINE)
        check("R3 R7 staircase entry", tab[(k - 2) / SC]);
      else
        check("R5 idle after last segment", idl);
      @(negedge clk);
    end
    wr_en = 1'b0;
    acq_active = 1'b1;
    if (last >= 0) model[wa[last]] = GW'(wd[last]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset value", '0);
    rst = 1'b0;
  endtask

  task automatic t_load();
    for (int i = 0; i < NS; i++) write_entry(i, (i * 97 + 13) % 1024);
    write_entry(3, 1023);
    write_entry(4, 0);
  endtask

  task automatic t_idle();
    @(negedge clk); idle_level = 10'd300;
    @(negedge clk); check("R6 idle follows", 10'd300);
    idle_level = 10'd512;
    @(negedge clk); check("R6 idle follows change", 10'd512);
  endtask

  task automatic t_plain_line();
    int z[3] = '{0, 0, 0};
    run_line(-1, 0, z, z, z);
  endtask

  task automatic t_restart();
    int rk;
    rk = 5 * SC + 3;
    @(negedge clk);
    line_start = 1'b1; acq_active = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (rk) @(negedge clk);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < LINE + 4; k++) begin
      if (k >= 2 && k - 2 < LINE) check("R4 restart staircase", model[(k - 2) / SC]);
      else if (k >= 2) check("R4 R5 idle after restarted line", idle_level);
      @(negedge clk);
    end
  endtask

  task automatic t_ignored_start();
    @(negedge clk);
    acq_active = 1'b0; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 0; k < 2 * SC; k++) begin
      check("R10 start ignored", idle_level);
      @(negedge clk);
    end
    acq_active = 1'b1;
  endtask

  task automatic t_defer();
    int wk[3] = '{10, 20, 30};
    int wa[3] = '{31, 6, 7};
    int wd[3] = '{777, 555, 222};
    logic [GW-1:0] old31, old6;
    old31 = model[31]; old6 = model[6];
    run_line(-1, 3, wk, wa, wd);
    // R8: only the last held write (entry 7) is committed
    t_plain_line();
    check_entry("R8 dropped write entry 31", 31, old31);
    check_entry("R8 dropped write entry 6", 6, old6);
    check_entry("R7 committed write entry 7", 7, 10'd222);
  endtask

  task automatic check_entry(input string req, input int idx, input logic [GW-1:0] exp);
    n_run++;
    if (model[idx] !== exp) begin
      n_fail++;
      $display("FAIL %s: model=%0d expected %0d", req, model[idx], exp);
    end
  endtask

  task automatic t_abort();
    int wk[3] = '{20, 0, 0};
    int wa[3] = '{9, 0, 0};
    int wd[3] = '{901, 0, 0};
    run_line(50, 1, wk, wa, wd);
    t_plain_line();   // shows entry 9 = 901 if the held write was committed (R9)
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_load();          // R2 entries 0..1023 checked through the lines below
    t_idle();
    t_plain_line();
    t_restart();
    t_ignored_start();
    t_defer();
    t_abort();
    t_idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule